// File: doc/BRIEF.md
# Radio Time-Signal Second and Minute Regenerator

A long-wave time-signal receiver gives a demodulated, active-low pulse train. Each second starts with a marker lasting 100 ms or 200 ms, and the marker for the final second of every minute is missing. This block rebuilds two clocks from that train. The first is a seconds clock with no holes: every second gets one short pulse of fixed width, and a synthetic pulse stands in for the missing one. The second is a separate minute strobe that marks the start of each new minute.

The raw input is inverted, synchronised to the system clock and debounced at a 1 ms tick. A seconds pulse is then fired on each marker's starting edge. A retriggerable timeout restarts on every marker start. It expires only when a marker fails to arrive. When it expires it opens a gap window. The window's opening edge injects the synthetic second. The window's closing edge produces the minute strobe. The window closes when the next marker arrives or, failing that, when its own length runs out. All times are counted in 1 ms ticks.

The block has no data stream and no back-pressure. Its inputs and outputs are plain level pins. Both outputs are active-high pulses that downstream logic samples on the system clock.

Top module: `sec_min_regen`

## Requirements
- R1: The receiver input is active-low: a marker begins when `rx_n` goes low. The return of `rx_n` to high produces no output.
- R2: A level change on `rx_n` is accepted only after it has held for `DEB_N` consecutive ticks (default 3). A low glitch shorter than that produces no output.
- R3: Each accepted marker start produces exactly one rising edge on `sec_pulse`, within two ticks of the accepted edge.
- R4: Every `sec_pulse` lasts `PULSE_MS` ticks (default 20). This holds for 100 ms markers, for 200 ms markers and for the synthetic pulse, and the minute pulse has the same width.
- R5: While markers keep arriving less than `TIMEOUT_MS` ticks apart, no synthetic second and no minute pulse is produced.
- R6: If `TIMEOUT_MS` ticks (default 1100) pass after an accepted marker start with no new one, a synthetic `sec_pulse` is produced and the gap window opens.
- R7: If no marker arrives while the window is open, the window closes after `GAP_MS` ticks (default 1100) with one `min_pulse`. After that, both outputs stay silent until the next marker.
- R8: A marker accepted while the window is open closes it at once. That marker produces a `min_pulse` together with its own normal `sec_pulse`.
- R9: After reset, neither output pulses until at least one marker start has been accepted.
- R10: While `rst` is high, and on the cycle after it, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms | input | 1 | One-cycle enable, once per millisecond |
| rx_n | input | 1 | Raw demodulated receiver output, active low |
| sec_pulse | output | 1 | Continuous seconds clock, `PULSE_MS` ticks high per second |
| min_pulse | output | 1 | Minute strobe, `PULSE_MS` ticks high at each minute start |

## Verification
The hardest case to reach from the ports is a marker that arrives while the gap window is open. It needs an accepted marker, then a silence longer than the timeout, then a marker that lands before the window runs out. Other cases that are easy to miss are the natural expiry of the window and the silence that must follow it. The bench shrinks the timeout, the window and the second length through parameters. It then drives a run of regular seconds with alternating marker widths, leaves one marker out, and sends the next marker at the two-second point, which falls inside the window. A final silence lets the window expire on its own.

// File: rtl/sec_min_pkg.sv
package sec_min_pkg;
  typedef enum logic [1:0] {
    GT_IDLE   = 2'd0,
    GT_ARMED  = 2'd1,
    GT_WINDOW = 2'd2
  } gap_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/smr_rx_cond.sv
module smr_rx_cond #(
  parameter int DEB_N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic rx_n,
  output logic mark_rise
);
  localparam int CW = $clog2(DEB_N + 1);

  logic          sync1, sync2;
  logic          level, level_q;
  logic [CW-1:0] agree_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      level     <= 1'b0;
      level_q   <= 1'b0;
      agree_cnt <= '0;
    end else begin
      sync1   <= ~rx_n;
      sync2   <= sync1;
      level_q <= level;
      if (tick_1ms) begin
        if (sync2 != level) begin
          if (agree_cnt == CW'(DEB_N - 1)) begin
            level     <= sync2;
            agree_cnt <= '0;
          end else begin
            agree_cnt <= agree_cnt + 1'b1;
          end
        end else begin
          agree_cnt <= '0;
        end
      end
    end
  end

  assign mark_rise = level & ~level_q;
endmodule

// File: rtl/smr_gap_timer.sv
module smr_gap_timer
  import sec_min_pkg::*;
#(
  parameter int TIMEOUT_MS = 1100,
  parameter int GAP_MS     = 1100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic mark_rise,
  output logic gap_start,
  output logic gap_end
);
  localparam int MAXC = max2(TIMEOUT_MS, GAP_MS);
  localparam int CW   = $clog2(MAXC + 1);

  gap_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= GT_IDLE;
      cnt       <= '0;
      gap_start <= 1'b0;
      gap_end   <= 1'b0;
    end else begin
      gap_start <= 1'b0;
      gap_end   <= 1'b0;
      if (mark_rise) begin
        if (state == GT_WINDOW) gap_end <= 1'b1;
        state <= GT_ARMED;
        cnt   <= '0;
      end else if (tick_1ms) begin
        case (state)
          GT_ARMED: begin
            if (cnt == CW'(TIMEOUT_MS - 1)) begin
              state     <= GT_WINDOW;
              cnt       <= '0;
              gap_start <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          GT_WINDOW: begin
            if (cnt == CW'(GAP_MS - 1)) begin
              state   <= GT_IDLE;
              cnt     <= '0;
              gap_end <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smr_one_shot.sv
module smr_one_shot #(
  parameter int PULSE_MS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_MS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      cnt   <= '0;
    end else if (trig) begin
      pulse <= 1'b1;
      cnt   <= '0;
    end else if (pulse && tick_1ms) begin
      if (cnt == CW'(PULSE_MS - 1)) begin
        pulse <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sec_min_regen.sv
module sec_min_regen #(
  parameter int DEB_N      = 3,
  parameter int TIMEOUT_MS = 1100,
  parameter int GAP_MS     = 1100,
  parameter int PULSE_MS   = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic rx_n,
  output logic sec_pulse,
  output logic min_pulse
);
  localparam int N_SHOTS = 3;   // 0: marker second, 1: synthetic second, 2: minute

  logic               mark_rise;
  logic               gap_start;
  logic               gap_end;
  logic [N_SHOTS-1:0] shot_trig;
  logic [N_SHOTS-1:0] shot_out;

  smr_rx_cond #(.DEB_N(DEB_N)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .tick_1ms  (tick_1ms),
    .rx_n      (rx_n),
    .mark_rise (mark_rise)
  );

  smr_gap_timer #(.TIMEOUT_MS(TIMEOUT_MS), .GAP_MS(GAP_MS)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .tick_1ms  (tick_1ms),
    .mark_rise (mark_rise),
    .gap_start (gap_start),
    .gap_end   (gap_end)
  );

  assign shot_trig = {gap_end, gap_start, mark_rise};

  for (genvar i = 0; i < N_SHOTS; i++) begin : g_shot
    smr_one_shot #(.PULSE_MS(PULSE_MS)) u_shot (
      .clk      (clk),
      .rst      (rst),
      .tick_1ms (tick_1ms),
      .trig     (shot_trig[i]),
      .pulse    (shot_out[i])
    );
  end

  assign sec_pulse = shot_out[0] | shot_out[1];
  assign min_pulse = shot_out[2];
endmodule

// File: rtl/sec_min_regen_chk.sv
module sec_min_regen_chk #(
  parameter int PULSE_MS = 20
) (
  input logic clk,
  input logic rst,
  input logic tick_1ms,
  input logic mark_rise,
  input logic gap_start,
  input logic gap_end,
  input logic sec_pulse,
  input logic min_pulse
);
  localparam int HW = $clog2(PULSE_MS + 2);

  logic          seen;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= 1'b0;
      hi_cnt <= '0;
    end else begin
      if (mark_rise) seen <= 1'b1;
      if (mark_rise || gap_start)
        hi_cnt <= '0;
      else if (!sec_pulse)
        hi_cnt <= '0;
      else if (tick_1ms && hi_cnt != HW'(PULSE_MS + 1))
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_quiet_in_reset_R10: assert property (@(posedge clk)
    rst |=> (!sec_pulse && !min_pulse));

  assert_silent_before_mark_R9: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (!sec_pulse && !min_pulse));

  assert_mark_gives_sec_R3: assert property (@(posedge clk) disable iff (rst)
    mark_rise |=> sec_pulse);

  assert_gap_fills_sec_R6: assert property (@(posedge clk) disable iff (rst)
    gap_start |=> sec_pulse);

  assert_end_gives_min_R7: assert property (@(posedge clk) disable iff (rst)
    gap_end |=> min_pulse);

  assert_min_only_from_end_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(min_pulse) |-> $past(gap_end));

  assert_open_close_apart_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gap_start, gap_end}));

  assert_sec_width_R4: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> (hi_cnt < HW'(PULSE_MS)));
endmodule

bind sec_min_regen sec_min_regen_chk #(.PULSE_MS(PULSE_MS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_1ms  (tick_1ms),
  .mark_rise (mark_rise),
  .gap_start (gap_start),
  .gap_end   (gap_end),
  .sec_pulse (sec_pulse),
  .min_pulse (min_pulse)
);

// File: tb/tb_sec_min_regen.sv
`timescale 1ns/100ps
module tb_sec_min_regen;
  localparam int TMO = 110;
  localparam int GAP = 110;
  localparam int PW  = 4;
  localparam int DEB = 3;
  localparam int SEC = 100;
  localparam int TOL = 2;

  logic clk = 1'b0, rst = 1'b1, tick_1ms = 1'b0, rx_n = 1'b1;
  logic sec_pulse, min_pulse;

  sec_min_regen #(.DEB_N(DEB), .TIMEOUT_MS(TMO), .GAP_MS(GAP), .PULSE_MS(PW)) dut (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .rx_n(rx_n),
    .sec_pulse(sec_pulse), .min_pulse(min_pulse)
  );

  always #2.5 clk = ~clk;

  int tick_no = 0, cyc = 0;
  int errs = 0, checks = 0;
  int sec_ev = 0, min_ev = 0;
  bit done = 0;
  int exp_sec[$], exp_min[$];
  string tag_sec[$], tag_min[$];

  always @(negedge clk) begin
    cyc = cyc + 1;
    tick_1ms <= (cyc % 2 == 0);
    if (cyc % 2 == 0) tick_no = tick_no + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= TOL) && (b - a <= TOL);
  endfunction

  // monitor: pops expectations as the outputs rise
  logic ps = 0, pm = 0;
  int srise = 0, mrise = 0;
  always @(negedge clk) begin
    int e;
    string t;
    if (!rst) begin
      if (sec_pulse && !ps) begin
        sec_ev++;
        srise = tick_no;
        if (exp_sec.size() == 0) chk(0, "R1/R5/R9 unexpected seconds pulse", tick_no, -1);
        else begin
          e = exp_sec.pop_front(); t = tag_sec.pop_front();
          chk(near(tick_no, e), t, tick_no, e);
        end
      end
      if (!sec_pulse && ps) chk(near(tick_no - srise, PW), "R4 seconds pulse width", tick_no - srise, PW);
      if (min_pulse && !pm) begin
        min_ev++;
        mrise = tick_no;
        if (exp_min.size() == 0) chk(0, "R5/R9 unexpected minute pulse", tick_no, -1);
        else begin
          e = exp_min.pop_front(); t = tag_min.pop_front();
          chk(near(tick_no, e), t, tick_no, e);
        end
      end
      if (!min_pulse && pm) chk(near(tick_no - mrise, PW), "R4 minute pulse width", tick_no - mrise, PW);
    end
    ps = sec_pulse;
    pm = min_pulse;
  end

  task automatic ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic want_sec(input int at, input string tag);
    exp_sec.push_back(at); tag_sec.push_back(tag);
  endtask

  task automatic want_min(input int at, input string tag);
    exp_min.push_back(at); tag_min.push_back(tag);
  endtask

  // one second: a low marker of len ticks, then idle to fill the second
  task automatic marker(input int len, input string tag, output int start);
    start = tick_no;
    want_sec(start + DEB, tag);
    rx_n = 1'b0;
    ticks(len);
    rx_n = 1'b1;
    ticks(SEC - len);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R3 run hung actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int t0, mins_before;
    ticks(5);
    chk(!sec_pulse, "R10 sec low in reset", sec_pulse, 0);
    chk(!min_pulse, "R10 min low in reset", min_pulse, 0);
    @(negedge clk); rst = 1'b0;
    chk(!sec_pulse && !min_pulse, "R10 outputs low after reset", sec_pulse | min_pulse, 0);

    ticks(300);
    chk(sec_ev == 0 && min_ev == 0, "R9 silent before first marker", sec_ev + min_ev, 0);

    rx_n = 1'b0; ticks(1); rx_n = 1'b1;   // glitch shorter than DEB_N
    ticks(200);
    chk(sec_ev == 0, "R2 short glitch ignored", sec_ev, 0);

    // regular seconds, alternating 100/200 ms style widths
    for (int i = 0; i < 6; i++) marker((i % 2) ? 20 : 10, "R1 R3 marker start", t0);
    chk(min_ev == 0, "R5 no minute during regular seconds", min_ev, 0);
    chk(sec_ev == 6, "R3 one pulse per marker, none at release", sec_ev, 6);

    // missing marker, then a marker inside the gap window
    want_sec(t0 + DEB + TMO, "R6 synthetic second");
    ticks(SEC);
    mins_before = min_ev;
    want_min(tick_no + DEB, "R8 minute on marker in window");
    marker(20, "R8 own second with window marker", t0);
    for (int i = 0; i < 3; i++) marker(10, "R5 regular seconds after minute", t0);
    chk(min_ev == mins_before + 1, "R8 exactly one minute pulse", min_ev - mins_before, 1);

    // markers stop: window expires on its own
    want_sec(t0 + DEB + TMO, "R6 synthetic second before expiry");
    want_min(t0 + DEB + TMO + GAP, "R7 minute at natural window end");
    ticks(500);
    mins_before = min_ev;
    ticks(300);
    chk(min_ev == mins_before, "R7 silent after expiry", min_ev - mins_before, 0);

    // recovery after expiry
    marker(10, "R7 restart on next marker", t0);
    want_sec(t0 + DEB + TMO, "R6 synthetic second after restart");
    want_min(t0 + DEB + TMO + GAP, "R7 minute after restart");
    ticks(400);

    chk(exp_sec.size() == 0, "R6 all expected seconds seen", exp_sec.size(), 0);
    chk(exp_min.size() == 0, "R7 all expected minutes seen", exp_min.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule